// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped system control peripheral that sits on a simple 32-bit register port. It holds fixed identification words and two free-running tick counters that run at 24 MHz and 100 MHz equivalent rates. It also has constant oscillator, flash and display status words, a 16-bit lock register, and a flags register that has its own clear address. Accesses are full words only. The decoded window is 0xD4 bytes. Anything unaligned, outside the window or unmapped reads as zero and ignores writes.

An indirect configuration channel reaches a set of small internal endpoints: several programmable oscillators and one temperature reporter. Software first loads the data register. It then writes the control word with the start bit set. The packed address fields in the control word pick an endpoint, and the write bit chooses the direction. On a write, the data register is copied into the endpoint. On a read, the endpoint's value is loaded into the data register. A request that names no endpoint is dropped without effect.

The port takes one access at a time. `req_ready` pulses for one cycle, one clock after the access is accepted, and `rsp_rdata` is valid with it.

Top module: `sysctl_regbank`

## Requirements
- R1: An access presented on `req_valid` is accepted at the next clock edge. `req_ready` is high for exactly one cycle after that edge, and the read data is valid in that same cycle. A write returns 0 on `rsp_rdata`.
- R2: A read returns 0 and a write has no effect when the byte offset is not a multiple of 4, is 0xD4 or above, or is not in the map. The map is: 0x00/0x04 processor IDs, 0x08 board ID, 0x10 lock, 0x14 flags, 0x18 flags clear, 0x20 slow tick, 0x24 fast tick, 0x30 flash, 0x34 display, 0x40–0x50 oscillator status 0–4, 0xA0 config data, 0xA4 config control, 0xA8 config status.
- R3: Both processor IDs and the board ID read as their parameter values (defaults 0x41000C90, 0x41000C91, 0x0178_0500). Writes to them are ignored.
- R4: The slow and fast tick counters read 0 at reset. Each clock, each counter gains at most 1, so that over d clocks it gains floor or ceil of d·SLOW_MHZ/CLK_MHZ (24/125) or d·FAST_MHZ/CLK_MHZ (100/125). Writes to them are ignored.
- R5: Flash reads 0 and display reads 0x00001F00. Oscillator status 0–4 read 0x00012C5C, 0x00002CC0, 0x00002C75, 0x00020211 and 0x00002C75. Writes to all of these are ignored.
- R6: A write to the lock register keeps bits [15:0] only. A read returns them zero-extended.
- R7: A write to flags loads all 32 bits. Any write to flags clear sets flags to 0.
- R8: Config status always reads 1 and config control always reads 0. A write to config status changes nothing.
- R9: A write to config control with bit 31 (start) clear has no effect.
- R10: The control word is laid out as start[31], write[30], dcc[29:26], function[25:20], site[17:16], position[15:12] and device[11:0]; bits [19:18] are ignored. An endpoint matches when dcc=0, site=1 and position=0. Oscillator n is function 1 with device n (n < 3), and the temperature endpoint is function 4 with device 0. With start set and write set, config data is written to the endpoint. With write clear, the endpoint value is loaded into config data. Writes to the temperature endpoint are ignored.
- R11: A started request that matches no endpoint leaves config data and all endpoints unchanged.
- R12: The temperature endpoint reads 25,000,000 when `temp_live` is low. When `temp_live` is high, it reads 0 if `temp_uc` is negative and `temp_uc` otherwise.
- R13: Oscillator n resets to 50,000,000 + n·25,000,000 Hz. A write of 0 Hz is rejected, and the old frequency is kept.
- R14: Synchronous reset clears flags, lock, config data and both tick counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| temp_live | input | 1 | A live temperature value is present |
| temp_uc | input | 32 | Signed temperature in micro-degrees C |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `req_ready` |

## Verification
The configuration channel is driven with control words built from random fields: dcc, site and position are mostly right but sometimes wrong, the function is oscillator, temperature or other, and the device runs past the oscillator count. The start, write and ignored bits 19:18 are random. This separates correct field decoding from decoding that ignores a field, stale data from a missed load, and a dropped unknown request from one that corrupts the data register. Random reads and writes across mapped, unmapped, unaligned and out-of-window offsets check the constant words, the lock truncation and flag clearing against a bench model. Directed cases cover zero-frequency writes, the three temperature cases, counter rates over a known interval, and the state after a second reset.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          ADDR_W       = 8,
  parameter int          WINDOW       = 'hD4,
  parameter logic [31:0] PROC_ID0     = 32'h4100_0C90,
  parameter logic [31:0] PROC_ID1     = 32'h4100_0C91,
  parameter logic [31:0] BOARD_ID     = 32'h0178_0500,
  parameter int          CLK_MHZ      = 125,
  parameter int          SLOW_MHZ     = 24,
  parameter int          FAST_MHZ     = 100,
  parameter int          NUM_OSC      = 3,
  parameter int          OSC_BASE_HZ  = 50_000_000,
  parameter int          OSC_STEP_HZ  = 25_000_000,
  parameter int          TEMP_IDLE_UC = 25_000_000,
  parameter logic [3:0]  EP_DCC       = 4'd0,
  parameter logic [1:0]  EP_SITE      = 2'd1,
  parameter logic [3:0]  EP_POS       = 4'd0,
  parameter logic [5:0]  FN_OSC       = 6'd1,
  parameter logic [5:0]  FN_TEMP      = 6'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              temp_live,
  input  logic [31:0]       temp_uc,
  output logic              req_ready,
  output logic [31:0]       rsp_rdata
);

  localparam int PH_W = $clog2(2 * CLK_MHZ + 1);

  localparam logic [31:0] OFF_PID0  = 32'h00;
  localparam logic [31:0] OFF_PID1  = 32'h04;
  localparam logic [31:0] OFF_BID   = 32'h08;
  localparam logic [31:0] OFF_LOCK  = 32'h10;
  localparam logic [31:0] OFF_FLAG  = 32'h14;
  localparam logic [31:0] OFF_FCLR  = 32'h18;
  localparam logic [31:0] OFF_TSLOW = 32'h20;
  localparam logic [31:0] OFF_TFAST = 32'h24;
  localparam logic [31:0] OFF_FLASH = 32'h30;
  localparam logic [31:0] OFF_DISP  = 32'h34;
  localparam logic [31:0] OFF_OSC0  = 32'h40;
  localparam logic [31:0] OFF_OSC1  = 32'h44;
  localparam logic [31:0] OFF_OSC2  = 32'h48;
  localparam logic [31:0] OFF_OSC3  = 32'h4C;
  localparam logic [31:0] OFF_OSC4  = 32'h50;
  localparam logic [31:0] OFF_CDATA = 32'hA0;
  localparam logic [31:0] OFF_CCTRL = 32'hA4;
  localparam logic [31:0] OFF_CSTAT = 32'hA8;

  localparam logic [29:0] KEY_MASK  = 30'h3FF3_FFFF;

  logic [31:0] a32;
  logic        sel_ok, acc, wr, rd;
  logic [31:0] flags_q, cfg_data;
  logic [15:0] lock_q;
  logic [31:0] tick_slow, tick_fast;
  logic [PH_W-1:0] ph_slow, ph_fast;
  logic [31:0] osc_hz [NUM_OSC];
  logic [NUM_OSC-1:0] osc_hit;
  logic        temp_hit, ep_known, cfg_go;
  logic [29:0] key_in;
  logic [31:0] temp_val, ep_rdata, rd_mux;

  assign a32    = 32'(req_addr);
  assign sel_ok = (a32 < 32'(WINDOW)) && (req_addr[1:0] == 2'b00);
  assign acc    = req_valid && !req_ready;
  assign wr     = acc && req_write && sel_ok;
  assign rd     = acc && !req_write;

  // endpoint decode from the packed control word
  assign key_in   = req_wdata[29:0] & KEY_MASK;
  assign temp_hit = key_in == {EP_DCC, FN_TEMP, 2'b00, EP_SITE, EP_POS, 12'd0};
  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc_dec
    assign osc_hit[i] = key_in == {EP_DCC, FN_OSC, 2'b00, EP_SITE, EP_POS, 12'(i)};
  end
  assign ep_known = (|osc_hit) || temp_hit;
  assign cfg_go   = wr && (a32 == OFF_CCTRL) && req_wdata[31] && ep_known;

  assign temp_val = !temp_live ? 32'(TEMP_IDLE_UC) : (temp_uc[31] ? 32'd0 : temp_uc);

  always_comb begin
    ep_rdata = temp_hit ? temp_val : 32'd0;
    for (int i = 0; i < NUM_OSC; i++)
      if (osc_hit[i]) ep_rdata = osc_hz[i];
  end

  always_comb begin
    rd_mux = 32'd0;
    if (sel_ok) begin
      case (a32)
        OFF_PID0:  rd_mux = PROC_ID0;
        OFF_PID1:  rd_mux = PROC_ID1;
        OFF_BID:   rd_mux = BOARD_ID;
        OFF_LOCK:  rd_mux = {16'd0, lock_q};
        OFF_FLAG:  rd_mux = flags_q;
        OFF_TSLOW: rd_mux = tick_slow;
        OFF_TFAST: rd_mux = tick_fast;
        OFF_FLASH: rd_mux = 32'd0;
        OFF_DISP:  rd_mux = 32'h0000_1F00;
        OFF_OSC0:  rd_mux = 32'h0001_2C5C;
        OFF_OSC1:  rd_mux = 32'h0000_2CC0;
        OFF_OSC2:  rd_mux = 32'h0000_2C75;
        OFF_OSC3:  rd_mux = 32'h0002_0211;
        OFF_OSC4:  rd_mux = 32'h0000_2C75;
        OFF_CDATA: rd_mux = cfg_data;
        OFF_CCTRL: rd_mux = 32'd0;
        OFF_CSTAT: rd_mux = 32'd1;
        default:   rd_mux = 32'd0;
      endcase
    end
  end

  // fractional tick counters
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_slow   <= '0;
      ph_fast   <= '0;
      tick_slow <= '0;
      tick_fast <= '0;
    end else begin
      if (ph_slow + PH_W'(SLOW_MHZ) >= PH_W'(CLK_MHZ)) begin
        ph_slow   <= ph_slow + PH_W'(SLOW_MHZ) - PH_W'(CLK_MHZ);
        tick_slow <= tick_slow + 32'd1;
      end else begin
        ph_slow   <= ph_slow + PH_W'(SLOW_MHZ);
      end
      if (ph_fast + PH_W'(FAST_MHZ) >= PH_W'(CLK_MHZ)) begin
        ph_fast   <= ph_fast + PH_W'(FAST_MHZ) - PH_W'(CLK_MHZ);
        tick_fast <= tick_fast + 32'd1;
      end else begin
        ph_fast   <= ph_fast + PH_W'(FAST_MHZ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_rdata <= 32'd0;
      flags_q   <= 32'd0;
      lock_q    <= 16'd0;
      cfg_data  <= 32'd0;
      for (int i = 0; i < NUM_OSC; i++)
        osc_hz[i] <= 32'(OSC_BASE_HZ + i * OSC_STEP_HZ);
    end else begin
      req_ready <= acc;
      if (acc) rsp_rdata <= rd ? rd_mux : 32'd0;
      if (wr) begin
        case (a32)
          OFF_LOCK:  lock_q   <= req_wdata[15:0];
          OFF_FLAG:  flags_q  <= req_wdata;
          OFF_FCLR:  flags_q  <= 32'd0;
          OFF_CDATA: cfg_data <= req_wdata;
          default: ;
        endcase
      end
      if (cfg_go) begin
        if (req_wdata[30]) begin
          for (int i = 0; i < NUM_OSC; i++)
            if (osc_hit[i] && cfg_data != 32'd0) osc_hz[i] <= cfg_data;
        end else begin
          cfg_data <= ep_rdata;
        end
      end
    end
  end

  assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && !sel_ok) |=> (rsp_rdata == 32'd0));

  assert_tick_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_fast == $past(tick_fast)) || (tick_fast == $past(tick_fast) + 32'd1));

  assert_lock_width_R6: assert property (@(posedge clk) disable iff (rst)
    (rd && sel_ok && a32 == OFF_LOCK) |=> (rsp_rdata[31:16] == 16'd0));

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && a32 == OFF_FCLR) |=> (flags_q == 32'd0));

  assert_stat_one_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && sel_ok && a32 == OFF_CSTAT) |=> (rsp_rdata == 32'd1));

  assert_unknown_keeps_data_R11: assert property (@(posedge clk) disable iff (rst)
    (wr && a32 == OFF_CCTRL && req_wdata[31] && !ep_known) |=> $stable(cfg_data));

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc_chk
    assert_osc_nonzero_R13: assert property (@(posedge clk) disable iff (rst)
      osc_hz[i] != 32'd0);
  end

endmodule

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
module sysctl_regbank_tb_top;

  localparam int NOSC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = 8'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        temp_live = 1'b0;
  logic [31:0] temp_uc = 32'd0;
  logic        req_ready;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  logic [31:0] exp_flags, exp_lock, exp_data;
  logic [31:0] exp_osc [NOSC];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysctl_regbank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .temp_live(temp_live),
    .temp_uc(temp_uc), .req_ready(req_ready), .rsp_rdata(rsp_rdata));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    bit seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(posedge clk); #1;
      if (k == 0) acc_cyc = cyc;
      if (req_ready) seen = 1;
    end
    r = rsp_rdata;
    if (!seen) check("R1 ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic logic [31:0] temp_exp();
    if (!temp_live) return 32'd25_000_000;
    return temp_uc[31] ? 32'd0 : temp_uc;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'hD4) return 32'd0;
    case (a)
      8'h00: return 32'h4100_0C90;
      8'h04: return 32'h4100_0C91;
      8'h08: return 32'h0178_0500;
      8'h10: return exp_lock;
      8'h14: return exp_flags;
      8'h34: return 32'h0000_1F00;
      8'h40: return 32'h0001_2C5C;
      8'h44: return 32'h0000_2CC0;
      8'h48: return 32'h0000_2C75;
      8'h4C: return 32'h0002_0211;
      8'h50: return 32'h0000_2C75;
      8'hA0: return exp_data;
      8'hA8: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_ctrl(input logic [31:0] d);
    logic common;
    int dev;
    if (!d[31]) return;
    common = d[29:26] == 4'd0 && d[17:16] == 2'd1 && d[15:12] == 4'd0;
    dev = int'(d[11:0]);
    if (common && d[25:20] == 6'd1 && dev < NOSC) begin
      if (d[30]) begin
        if (exp_data != 32'd0) exp_osc[dev] = exp_data;
      end else exp_data = exp_osc[dev];
    end else if (common && d[25:20] == 6'd4 && dev == 0 && !d[30]) begin
      exp_data = temp_exp();
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h10: exp_lock  = {16'd0, d[15:0]};
      8'h14: exp_flags = d;
      8'h18: exp_flags = 32'd0;
      8'hA0: exp_data  = d;
      8'hA4: model_ctrl(d);
      default: ;
    endcase
  endtask

  task automatic model_reset();
    exp_flags = 0; exp_lock = 0; exp_data = 0;
    for (int i = 0; i < NOSC; i++) exp_osc[i] = 32'(50_000_000 + i * 25_000_000);
  endtask

  function automatic logic [31:0] ctrl_word(input bit st, input bit w, input bit good,
                                            input logic [5:0] fn, input logic [11:0] dev);
    logic [3:0] dcc = good ? 4'd0 : 4'($urandom);
    logic [1:0] site = good ? 2'd1 : 2'($urandom);
    logic [3:0] pos = good ? 4'd0 : 4'($urandom);
    return {st, w, dcc, fn, 2'($urandom), site, pos, dev};
  endfunction

  task automatic osc_read(input int n, output logic [31:0] v);
    logic [31:0] r;
    bus(1, 8'hA4, ctrl_word(1, 0, 1, 6'd1, 12'(n)), r);
    bus(0, 8'hA0, 0, v);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  logic [31:0] r, r2, t1;
  int c1, lo;
  logic [7:0] maplist [18] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24,
                               8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50,
                               8'hA0, 8'hA4, 8'hA8};

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (5) @(posedge clk);
    #1 check("R1 ready low in reset", 32'(req_ready), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R14 reset state
    bus(0, 8'h14, 0, r); check("R14 flags reset", r, 32'd0);
    bus(0, 8'h10, 0, r); check("R14 lock reset", r, 32'd0);
    bus(0, 8'hA0, 0, r); check("R14 data reset", r, 32'd0);
    bus(0, 8'h20, 0, r); check("R14 slow tick near zero", 32'(r < 32'd5), 32'd1);

    // R1 ready is a single pulse and write returns 0
    bus(1, 8'h14, 32'hDEAD_BEEF, r); model_write(8'h14, 32'hDEAD_BEEF);
    check("R1 write rdata zero", r, 32'd0);
    @(posedge clk); #1 check("R1 ready single pulse", 32'(req_ready), 32'd0);

    // R3/R5 ignored writes, R2 out of window
    bus(1, 8'h00, 32'h1234_5678, r); bus(0, 8'h00, 0, r);
    check("R3 pid0 write ignored", r, 32'h4100_0C90);
    bus(1, 8'h40, 32'hFFFF_FFFF, r); bus(0, 8'h40, 0, r);
    check("R5 osc status write ignored", r, 32'h0001_2C5C);
    bus(0, 8'hD4, 0, r); check("R2 beyond window", r, 32'd0);
    bus(0, 8'h15, 0, r); check("R2 unaligned read", r, 32'd0);
    bus(1, 8'h16, 32'h0, r); bus(0, 8'h14, 0, r);
    check("R2 unaligned write ignored", r, 32'hDEAD_BEEF);

    // R6 lock truncation, R7 clear
    bus(1, 8'h10, 32'hABCD_1234, r); bus(0, 8'h10, 0, r);
    check("R6 lock low half", r, 32'h0000_1234);
    bus(1, 8'h18, 32'h5555_5555, r); bus(0, 8'h14, 0, r);
    check("R7 flags cleared", r, 32'd0);
    model_write(8'h10, 32'hABCD_1234); model_write(8'h18, 0);

    // R8 status/control
    bus(1, 8'hA8, 32'h0, r); bus(0, 8'hA8, 0, r); check("R8 status reads 1", r, 32'd1);
    bus(0, 8'hA4, 0, r); check("R8 control reads 0", r, 32'd0);

    // R13 defaults and zero rejection
    for (int i = 0; i < NOSC; i++) begin
      osc_read(i, r); check("R13 osc default", r, exp_osc[i]);
    end
    bus(1, 8'hA0, 32'd0, r);
    bus(1, 8'hA4, ctrl_word(1, 1, 1, 6'd1, 12'd1), r);
    osc_read(1, r); check("R13 zero rejected", r, 32'd75_000_000);
    bus(1, 8'hA0, 32'd33_000_000, r);
    bus(1, 8'hA4, ctrl_word(1, 1, 1, 6'd1, 12'd2), r);
    exp_osc[2] = 32'd33_000_000;
    osc_read(2, r); check("R10 osc write readback", r, 32'd33_000_000);

    // R9 start clear
    bus(1, 8'hA0, 32'h0BAD_0BAD, r);
    bus(1, 8'hA4, ctrl_word(0, 0, 1, 6'd1, 12'd0), r);
    bus(0, 8'hA0, 0, r); check("R9 no start keeps data", r, 32'h0BAD_0BAD);

    // R11 unknown endpoint
    bus(1, 8'hA4, ctrl_word(1, 0, 1, 6'd1, 12'd7), r);
    bus(0, 8'hA0, 0, r); check("R11 unknown keeps data", r, 32'h0BAD_0BAD);
    exp_data = 32'h0BAD_0BAD;

    // R12 temperature cases
    temp_live = 1'b0;
    bus(1, 8'hA4, ctrl_word(1, 0, 1, 6'd4, 12'd0), r);
    bus(0, 8'hA0, 0, r); check("R12 idle temperature", r, 32'd25_000_000);
    temp_live = 1'b1; temp_uc = -32'sd5_000_000;
    bus(1, 8'hA4, ctrl_word(1, 0, 1, 6'd4, 12'd0), r);
    bus(0, 8'hA0, 0, r); check("R12 negative clamped", r, 32'd0);
    temp_uc = 32'd41_250_000;
    bus(1, 8'hA4, ctrl_word(1, 0, 1, 6'd4, 12'd0), r);
    bus(0, 8'hA0, 0, r); check("R12 live temperature", r, 32'd41_250_000);
    exp_data = 32'd41_250_000;

    // R4 counter rates
    bus(0, 8'h20, 0, t1); c1 = acc_cyc;
    repeat (137) @(posedge clk);
    bus(0, 8'h20, 0, r);
    lo = ((acc_cyc - c1) * 24) / 125;
    check("R4 slow rate", 32'((r - t1) >= 32'(lo) && (r - t1) <= 32'(lo + 1)), 32'd1);
    bus(1, 8'h24, 32'hFFFF_0000, r);
    bus(0, 8'h24, 0, t1); c1 = acc_cyc;
    repeat (211) @(posedge clk);
    bus(0, 8'h24, 0, r);
    lo = ((acc_cyc - c1) * 100) / 125;
    check("R4 fast rate, write ignored", 32'((r - t1) >= 32'(lo) && (r - t1) <= 32'(lo + 1)), 32'd1);

    // random mix against the model
    for (int it = 0; it < 600; it++) begin
      int kind = int'($urandom % 10);
      logic [7:0] a = ($urandom % 4 == 0) ? 8'($urandom) : maplist[$urandom % 18];
      if (kind < 4) begin
        logic [31:0] d = $urandom;
        bus(1, a, d, r); model_write(a, d);
      end else if (kind < 7) begin
        bus(0, a, 0, r);
        if (a != 8'h20 && a != 8'h24) check("R2/R3/R5/R6/R7 random read", r, model_read(a));
      end else begin
        logic [31:0] d = ($urandom % 3 == 0) ? 32'd0 : $urandom;
        logic [31:0] cw = ctrl_word($urandom % 6 != 0, $urandom % 2 == 1, $urandom % 4 != 0,
                                    ($urandom % 4 == 0) ? 6'($urandom) :
                                    (($urandom % 3 == 0) ? 6'd4 : 6'd1),
                                    12'($urandom % 5));
        temp_uc = ($urandom % 4 == 0) ? -32'sd7 : 32'($urandom % 90_000_000);
        temp_live = $urandom % 5 != 0;
        bus(1, 8'hA0, d, r); model_write(8'hA0, d);
        bus(1, 8'hA4, cw, r); model_write(8'hA4, cw);
        bus(0, 8'hA0, 0, r); check("R10/R11 channel data", r, exp_data);
      end
    end
    for (int i = 0; i < NOSC; i++) begin
      osc_read(i, r); check("R10/R13 osc final", r, exp_osc[i]); exp_data = r;
    end

    // second reset, R14 and R13 defaults return
    bus(1, 8'h14, 32'h1, r); bus(1, 8'h10, 32'h2, r);
    do_reset();
    bus(0, 8'h14, 0, r); check("R14 flags after reset", r, 32'd0);
    bus(0, 8'h10, 0, r); check("R14 lock after reset", r, 32'd0);
    bus(0, 8'hA0, 0, r); check("R14 data after reset", r, 32'd0);
    bus(0, 8'h24, 0, r2); check("R14 fast tick after reset", 32'(r2 < 32'd8), 32'd1);
    osc_read(0, r); check("R13 osc0 default after reset", r, 32'd50_000_000);

    summary();
    $finish;
  end

endmodule